// File: doc/BRIEF.md
# System Clock Mode Controller

This block manages the internal clock of a small 8-bit controller. A 4-bit mode word picks the source and divide ratio of the internal clock phi, and also decides whether the main and sub oscillators run. Both oscillators are modelled as single-cycle tick strobes. The block turns those ticks into a phi clock-enable pulse, `phi_en`. The CPU writes new mode words, and the block accepts only those that move one step along a fixed graph of allowed transitions. Any other word is rejected and flagged.

The block also handles the halt states. Stop halts both oscillators, while wait only freezes phi. Both end on a wake strobe. When leaving stop, the block normally inserts an oscillation-stabilization delay whose length and tick source depend on the resumed mode. Moving from the slow sub clock back to a main-clock mode is held pending until the main oscillator has had time to settle. An automatic switch into middle speed can be started with one strobe, and it runs a programmable wait before the mode changes. Every delay is a parameter counted in oscillator ticks.

Top module: `sysclk_mode_ctrl`

## Requirements
- R1: After reset `mode_q` is 4'b0100 (middle speed, main running, sub stopped), and `busy`, `illegal_wr` and `phi_en` are 0.
- R2: `phi_en` is high in the same cycle as the tick that completes a divided period. The divided periods are 2 main ticks for select 00, 8 main ticks for select 01 and 2 sub ticks for select 10. The divide count restarts from zero on every mode change and while phi is frozen.
- R3: The mode word has select in bits [3:2], main-oscillator stop in bit [1] and sub-oscillator enable in bit [0]. `main_run` = !bit1 and `sub_run` = bit0 outside stop. Bit 1 can be 1 only with select 10, and select 10 always has bit 0 = 1.
- R4: A write is accepted only if it equals the current word or follows one edge of the graph 0100–0101, 0000–0001, 0100–0000, 0101–0001, 0101–1001, 0001–1001, 1001–1011. A word with select 11 is never accepted.
- R5: A rejected write leaves `mode_q` unchanged, and `illegal_wr` is high for exactly the one cycle after the write edge.
- R6: An accepted write from select 10 to select 00 or 01 raises `busy` and keeps phi running on the sub clock. The new word takes effect at the edge that samples the MAIN_STAB-th main tick.
- R7: `stop_req` halts both oscillator outputs and freezes `phi_en`. `wait_req` freezes `phi_en` only. A `wake` strobe ends wait at once, and both halts return to the same mode.
- R8: On `wake` from stop with `dly_skip` = 0, `busy` stays high for MAIN_RESUME main ticks in select 00/01. In select 10 it stays high for sub ticks: SUB_LONG when `lsrc_sel` = 0, SUB_SHORT when `lsrc_sel` = 1. With `dly_skip` = 1 there is no delay.
- R9: `auto_start` with `auto_en` = 1 raises `busy` for AUTO_UNIT×(`auto_wsel`+1) main ticks. It then sets the mode to select 01 with main running and the sub bit unchanged. With `auto_en` = 0 the strobe has no effect.
- R10: A write while `busy` is high is ignored: `mode_q` keeps its value and `illegal_wr` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Mode-word write strobe |
| wr_mode | input | 4 | Mode word to write |
| main_tick | input | 1 | Main-oscillator tick strobe |
| sub_tick | input | 1 | Sub-oscillator tick strobe |
| stop_req | input | 1 | Enter stop |
| wait_req | input | 1 | Enter wait |
| wake | input | 1 | End stop or wait |
| dly_skip | input | 1 | Skip the delay when leaving stop |
| lsrc_sel | input | 1 | Short (1) or long (0) low-speed resume delay |
| auto_en | input | 1 | Auto-switch enable |
| auto_start | input | 1 | Auto-switch start strobe |
| auto_wsel | input | 2 | Auto-switch wait select |
| mode_q | output | 4 | Current mode word |
| phi_en | output | 1 | Internal-clock enable pulse |
| busy | output | 1 | A stabilization or auto-switch wait is running |
| illegal_wr | output | 1 | Rejected-write pulse |
| main_run | output | 1 | Main oscillator running |
| sub_run | output | 1 | Sub oscillator running |

## Verification
The results fall due at three different times.

- `phi_en` is combinational on the tick, so the bench raises a tick at a falling edge and samples `phi_en` 1 ns later, in the same cycle.
- Mode-word updates, `busy` changes and `illegal_wr` are registered. The bench reads them at the falling edge after the rising edge that sampled the write, the strobe or the final tick.
- A delay of N ticks is checked twice: after N−1 ticks, when `busy` must still be high, and after the N-th tick, when it must be low.

// File: rtl/clkm_pkg.sv
package clkm_pkg;

  typedef enum logic [1:0] {
    SEL_HIGH = 2'b00,
    SEL_MID  = 2'b01,
    SEL_LOW  = 2'b10,
    SEL_RSV  = 2'b11
  } sel_e;

  typedef struct packed {
    logic [1:0] sel;
    logic       main_off;
    logic       sub_on;
  } cmode_t;

  typedef enum logic [2:0] {
    ST_RUN, ST_WAIT, ST_STOP, ST_RESUME, ST_STAB, ST_AUTO
  } cst_e;

  localparam cmode_t RESET_MODE = '{sel: 2'b01, main_off: 1'b0, sub_on: 1'b0};

  function automatic logic is_fast(input logic [1:0] s);
    return (s == SEL_HIGH) || (s == SEL_MID);
  endfunction

  // one step along the allowed-transition graph
  function automatic logic step_ok(input cmode_t cur, input cmode_t nxt);
    logic fc, fn;
    fc = is_fast(cur.sel);
    fn = is_fast(nxt.sel);
    if (nxt.sel == SEL_RSV) return 1'b0;
    if (nxt == cur) return 1'b1;
    if (fc && fn)
      return !cur.main_off && !nxt.main_off &&
             ((cur.sel == nxt.sel) != (cur.sub_on == nxt.sub_on));
    if (fc != fn)
      return cur.sub_on && nxt.sub_on && !cur.main_off && !nxt.main_off;
    return cur.sub_on && nxt.sub_on;
  endfunction

  // source ticks per phi period
  function automatic logic [3:0] div_of(input logic [1:0] s);
    return (s == SEL_MID) ? 4'd8 : 4'd2;
  endfunction

endpackage

// File: rtl/clkm_phi_div.sv
module clkm_phi_div
  import clkm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic       main_tick,
  input  logic       sub_tick,
  input  logic [1:0] sel,
  output logic       phi_en
);
  logic [2:0] cnt_q;
  logic       tick;
  logic       wrap;

  assign tick   = (sel == SEL_LOW) ? sub_tick : main_tick;
  assign wrap   = ({1'b0, cnt_q} == (div_of(sel) - 4'd1));
  assign phi_en = run && tick && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n || clr || !run) cnt_q <= '0;
    else if (tick)             cnt_q <= wrap ? 3'd0 : cnt_q + 3'd1;
  end

  a_r2_phi_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    phi_en |-> (main_tick || sub_tick));
endmodule

// File: rtl/clkm_delay.sv
module clkm_delay #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          tick,
  output logic          done
);
  logic [DW-1:0] cnt_q;

  assign done = tick && !load && (cnt_q == DW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (load)                     cnt_q <= load_val;
    else if (tick && cnt_q != '0)      cnt_q <= cnt_q - DW'(1);
  end
endmodule

// File: rtl/clkm_seq.sv
module clkm_seq
  import clkm_pkg::*;
#(
  parameter int MAIN_RESUME = 8000,
  parameter int SUB_LONG    = 8192,
  parameter int SUB_SHORT   = 512,
  parameter int MAIN_STAB   = 8000,
  parameter int AUTO_UNIT   = 1000,
  parameter int DW          = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_mode,
  input  logic          stop_req,
  input  logic          wait_req,
  input  logic          wake,
  input  logic          dly_skip,
  input  logic          lsrc_sel,
  input  logic          auto_en,
  input  logic          auto_start,
  input  logic [1:0]    auto_wsel,
  input  logic          dly_done,
  output logic [3:0]    mode_bits,
  output logic          busy,
  output logic          illegal_wr,
  output logic          phi_run,
  output logic          mode_upd,
  output logic          use_sub,
  output logic          dly_load,
  output logic [DW-1:0] dly_val,
  output logic          main_run,
  output logic          sub_run
);
  cmode_t mode_q, mode_n, pend_q, pend_n, wr_new;
  cst_e   st_q, st_n;
  logic   ill_n;

  function automatic logic [DW-1:0] resume_len(input logic low, input logic short_sel);
    if (!low)      return DW'(MAIN_RESUME);
    if (short_sel) return DW'(SUB_SHORT);
    return DW'(SUB_LONG);
  endfunction

  function automatic logic [DW-1:0] auto_len(input logic [1:0] wsel);
    return DW'(AUTO_UNIT * (int'(wsel) + 1));
  endfunction

  always_comb begin
    mode_n   = mode_q;
    pend_n   = pend_q;
    st_n     = st_q;
    ill_n    = 1'b0;
    dly_load = 1'b0;
    dly_val  = '0;
    wr_new   = cmode_t'(wr_mode);
    unique case (st_q)
      ST_RUN: begin
        if (wr_en) begin
          if (!step_ok(mode_q, wr_new)) ill_n = 1'b1;
          else if (mode_q.sel == SEL_LOW && is_fast(wr_new.sel)) begin
            pend_n   = wr_new;
            st_n     = ST_STAB;
            dly_load = 1'b1;
            dly_val  = DW'(MAIN_STAB);
          end else mode_n = wr_new;
        end else if (stop_req) st_n = ST_STOP;
        else if (wait_req)     st_n = ST_WAIT;
        else if (auto_en && auto_start) begin
          pend_n   = '{sel: SEL_MID, main_off: 1'b0, sub_on: mode_q.sub_on};
          st_n     = ST_AUTO;
          dly_load = 1'b1;
          dly_val  = auto_len(auto_wsel);
        end
      end
      ST_WAIT: if (wake) st_n = ST_RUN;
      ST_STOP: begin
        if (wake) begin
          if (dly_skip) st_n = ST_RUN;
          else begin
            st_n     = ST_RESUME;
            dly_load = 1'b1;
            dly_val  = resume_len(mode_q.sel == SEL_LOW, lsrc_sel);
          end
        end
      end
      ST_RESUME: if (dly_done) st_n = ST_RUN;
      ST_STAB, ST_AUTO: begin
        if (dly_done) begin
          mode_n = pend_q;
          st_n   = ST_RUN;
        end
      end
      default: st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= RESET_MODE;
      pend_q     <= RESET_MODE;
      st_q       <= ST_RUN;
      illegal_wr <= 1'b0;
    end else begin
      mode_q     <= mode_n;
      pend_q     <= pend_n;
      st_q       <= st_n;
      illegal_wr <= ill_n;
    end
  end

  assign mode_bits = mode_q;
  assign busy      = (st_q == ST_RESUME) || (st_q == ST_STAB) || (st_q == ST_AUTO);
  assign phi_run   = (st_q == ST_RUN) || (st_q == ST_STAB);
  assign mode_upd  = (mode_n != mode_q);
  assign use_sub   = (st_q == ST_RESUME) && (mode_q.sel == SEL_LOW);
  assign main_run  = (st_q != ST_STOP) && (!mode_q.main_off || st_q == ST_AUTO);
  assign sub_run   = (st_q != ST_STOP) && mode_q.sub_on;

  a_r4_no_reserved_select: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.sel != SEL_RSV);
  a_r3_main_stop_only_low: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q.main_off |-> (mode_q.sel == SEL_LOW));
  a_r3_low_needs_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.sel == SEL_LOW) |-> mode_q.sub_on);
  a_r5_rejected_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_wr |-> (mode_q == $past(mode_q)));
  a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !dly_done) |=> (mode_q == $past(mode_q)));
endmodule

// File: rtl/sysclk_mode_ctrl.sv
module sysclk_mode_ctrl
  import clkm_pkg::*;
#(
  parameter int MAIN_RESUME = 8000,
  parameter int SUB_LONG    = 8192,
  parameter int SUB_SHORT   = 512,
  parameter int MAIN_STAB   = 8000,
  parameter int AUTO_UNIT   = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] wr_mode,
  input  logic       main_tick,
  input  logic       sub_tick,
  input  logic       stop_req,
  input  logic       wait_req,
  input  logic       wake,
  input  logic       dly_skip,
  input  logic       lsrc_sel,
  input  logic       auto_en,
  input  logic       auto_start,
  input  logic [1:0] auto_wsel,
  output logic [3:0] mode_q,
  output logic       phi_en,
  output logic       busy,
  output logic       illegal_wr,
  output logic       main_run,
  output logic       sub_run
);
  localparam int M1   = (MAIN_RESUME > SUB_LONG) ? MAIN_RESUME : SUB_LONG;
  localparam int M2   = (M1 > MAIN_STAB) ? M1 : MAIN_STAB;
  localparam int MAXV = (M2 > AUTO_UNIT * 4) ? M2 : AUTO_UNIT * 4;
  localparam int DW   = $clog2(MAXV + 1);

  logic          phi_run, mode_upd, use_sub, dly_load, dly_done;
  logic [DW-1:0] dly_val;

  clkm_seq #(
    .MAIN_RESUME(MAIN_RESUME), .SUB_LONG(SUB_LONG), .SUB_SHORT(SUB_SHORT),
    .MAIN_STAB(MAIN_STAB), .AUTO_UNIT(AUTO_UNIT), .DW(DW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode),
    .stop_req(stop_req), .wait_req(wait_req), .wake(wake),
    .dly_skip(dly_skip), .lsrc_sel(lsrc_sel), .auto_en(auto_en),
    .auto_start(auto_start), .auto_wsel(auto_wsel), .dly_done(dly_done),
    .mode_bits(mode_q), .busy(busy), .illegal_wr(illegal_wr),
    .phi_run(phi_run), .mode_upd(mode_upd), .use_sub(use_sub),
    .dly_load(dly_load), .dly_val(dly_val),
    .main_run(main_run), .sub_run(sub_run)
  );

  clkm_delay #(.DW(DW)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(dly_val),
    .tick(use_sub ? sub_tick : main_tick), .done(dly_done)
  );

  clkm_phi_div u_div (
    .clk(clk), .rst_n(rst_n), .run(phi_run), .clr(mode_upd),
    .main_tick(main_tick), .sub_tick(sub_tick), .sel(mode_q[3:2]),
    .phi_en(phi_en)
  );

  a_r8_delay_done_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dly_done |-> busy);
  a_r7_no_phi_oscs_halted: assert property (@(posedge clk) disable iff (!rst_n)
    (!main_run && !sub_run) |-> !phi_en);
endmodule

// File: tb/tb_sysclk_mode_ctrl.sv
module tb_sysclk_mode_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, main_tick = 0, sub_tick = 0, stop_req = 0, wait_req = 0;
  logic wake = 0, dly_skip = 0, lsrc_sel = 0, auto_en = 0, auto_start = 0;
  logic [3:0] wr_mode = '0;
  logic [1:0] auto_wsel = '0;
  logic [3:0] mode_q;
  logic phi_en, busy, illegal_wr, main_run, sub_run;

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  sysclk_mode_ctrl #(
    .MAIN_RESUME(5), .SUB_LONG(9), .SUB_SHORT(3), .MAIN_STAB(4), .AUTO_UNIT(2)
  ) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode),
    .main_tick(main_tick), .sub_tick(sub_tick), .stop_req(stop_req),
    .wait_req(wait_req), .wake(wake), .dly_skip(dly_skip), .lsrc_sel(lsrc_sel),
    .auto_en(auto_en), .auto_start(auto_start), .auto_wsel(auto_wsel),
    .mode_q(mode_q), .phi_en(phi_en), .busy(busy), .illegal_wr(illegal_wr),
    .main_run(main_run), .sub_run(sub_run)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done_flag) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step(); rst_n = 1; step();
  endtask

  task automatic wr(input logic [3:0] m);
    wr_en = 1; wr_mode = m; step(); wr_en = 0;
  endtask

  task automatic ticks(input bit on_main, input int n, output int pulses, output int first);
    pulses = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      if (on_main) main_tick = 1; else sub_tick = 1;
      #1;
      if (phi_en) begin pulses++; if (first == 0) first = i; end
      step();
      main_tick = 0; sub_tick = 0;
    end
  endtask

  task automatic goto(input logic [3:0] m);
    do_reset();
    case (m)
      4'h5: wr(4'h5);
      4'h0: wr(4'h0);
      4'h1: begin wr(4'h5); wr(4'h1); end
      4'h9: begin wr(4'h5); wr(4'h9); end
      4'hB: begin wr(4'h5); wr(4'h9); wr(4'hB); end
      default: ;
    endcase
  endtask

  // allowed edges, written as an explicit adjacency list
  function automatic bit edge_ok(input logic [3:0] a, input logic [3:0] b);
    if (a == b) return 1;
    case ({a, b})
      8'h45, 8'h54, 8'h40, 8'h04, 8'h51, 8'h15, 8'h01, 8'h10,
      8'h59, 8'h95, 8'h19, 8'h91, 8'h9B, 8'hB9: return 1;
      default: return 0;
    endcase
  endfunction

  initial begin
    int p, f;
    logic [3:0] bases [6];
    bases = '{4'h4, 4'h5, 4'h0, 4'h1, 4'h9, 4'hB};
    do_reset();
    // R1 reset state
    chk("R1", "mode", mode_q, 4'h4);
    chk("R1", "busy", busy, 0);
    chk("R1", "illegal", illegal_wr, 0);
    chk("R3", "main_run", main_run, 1);
    chk("R3", "sub_run", sub_run, 0);

    // R2 divider per select
    ticks(1, 16, p, f);
    chk("R2", "mid pulses", p, 2); chk("R2", "mid first", f, 8);
    goto(4'h0); ticks(1, 6, p, f);
    chk("R2", "high pulses", p, 3); chk("R2", "high first", f, 2);
    goto(4'h9); ticks(1, 6, p, f);
    chk("R2", "low ignores main", p, 0);
    ticks(0, 6, p, f);
    chk("R2", "low pulses", p, 3); chk("R2", "low first", f, 2);
    chk("R3", "low sub_run", sub_run, 1);
    goto(4'hB);
    chk("R3", "main stopped", main_run, 0);

    // R4 R5 sweep of every word from every reachable mode
    foreach (bases[bi]) begin
      for (int v = 0; v < 16; v++) begin
        bit ok, stab;
        goto(bases[bi]);
        ok = edge_ok(bases[bi], 4'(v));
        stab = ok && bases[bi][3:2] == 2'b10 && v[3:2] != 2'b10;
        wr(4'(v));
        if (stab) begin
          chk("R6", "pending busy", busy, 1);
          chk("R6", "pending mode", mode_q, bases[bi]);
          ticks(1, 3, p, f);
          chk("R6", "still busy", busy, 1);
          ticks(1, 1, p, f);
          chk("R6", "applied", mode_q, v);
          chk("R6", "busy cleared", busy, 0);
        end else begin
          chk("R4", "mode after write", mode_q, ok ? v : int'(bases[bi]));
          chk("R5", "illegal flag", illegal_wr, !ok);
          step();
          chk("R5", "flag one cycle", illegal_wr, 0);
        end
      end
    end

    // R6 phi keeps running on sub clock while pending, R10 write ignored
    goto(4'h9); wr(4'h5);
    ticks(0, 4, p, f);
    chk("R6", "sub phi while pending", p, 2);
    wr(4'h0);
    chk("R10", "busy write mode", mode_q, 4'h9);
    chk("R10", "busy write no flag", illegal_wr, 0);
    ticks(1, 4, p, f);
    chk("R10", "pending word kept", mode_q, 4'h5);

    // R7 R8 stop in middle speed, main-tick resume delay
    goto(4'h4);
    stop_req = 1; step(); stop_req = 0;
    chk("R7", "stop main_run", main_run, 0);
    chk("R7", "stop sub_run", sub_run, 0);
    ticks(1, 8, p, f);
    chk("R7", "stop phi", p, 0);
    wake = 1; step(); wake = 0;
    chk("R8", "resume busy", busy, 1);
    ticks(1, 4, p, f);
    chk("R8", "busy before 5th", busy, 1);
    chk("R8", "no phi in delay", p, 0);
    ticks(1, 1, p, f);
    chk("R8", "busy after 5th", busy, 0);
    chk("R7", "mode kept", mode_q, 4'h4);
    ticks(1, 8, p, f);
    chk("R7", "phi resumes", p, 1);

    // R8 low-speed long and short
    for (int s = 0; s < 2; s++) begin
      int n;
      n = (s == 0) ? 9 : 3;
      goto(4'h9);
      stop_req = 1; step(); stop_req = 0;
      lsrc_sel = 1'(s); wake = 1; step(); wake = 0;
      ticks(1, n, p, f);
      chk("R8", "main ticks ignored in low resume", busy, 1);
      ticks(0, n - 1, p, f);
      chk("R8", "low busy before last", busy, 1);
      ticks(0, 1, p, f);
      chk("R8", "low busy after last", busy, 0);
    end
    lsrc_sel = 0;

    // R8 skip
    goto(4'h0);
    stop_req = 1; step(); stop_req = 0;
    dly_skip = 1; wake = 1; step(); wake = 0; dly_skip = 0;
    chk("R8", "skip no busy", busy, 0);
    ticks(1, 2, p, f);
    chk("R8", "skip phi", p, 1);

    // R7 wait
    goto(4'h4);
    wait_req = 1; step(); wait_req = 0;
    chk("R7", "wait main_run", main_run, 1);
    ticks(1, 8, p, f);
    chk("R7", "wait phi", p, 0);
    wake = 1; step(); wake = 0;
    chk("R7", "wait exit no busy", busy, 0);
    ticks(1, 8, p, f);
    chk("R7", "wait phi resumes", p, 1);

    // R9 auto switch
    goto(4'h0);
    auto_en = 0; auto_start = 1; step(); auto_start = 0;
    chk("R9", "disabled busy", busy, 0);
    chk("R9", "disabled mode", mode_q, 4'h0);
    auto_en = 1; auto_wsel = 2; auto_start = 1; step(); auto_start = 0;
    chk("R9", "auto busy", busy, 1);
    ticks(1, 5, p, f);
    chk("R9", "auto busy before 6th", busy, 1);
    chk("R9", "auto mode unchanged", mode_q, 4'h0);
    ticks(1, 1, p, f);
    chk("R9", "auto done", busy, 0);
    chk("R9", "auto mode", mode_q, 4'h4);
    goto(4'hB);
    auto_wsel = 0; auto_start = 1; step(); auto_start = 0;
    chk("R9", "auto restarts main", main_run, 1);
    ticks(1, 2, p, f);
    chk("R9", "auto from low", mode_q, 4'h5);
    auto_en = 0;

    done_flag = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule